// File: doc/BRIEF.md
# I2C Serial EEPROM Read Controller

This block is the target-side protocol engine for a byte-addressed serial EEPROM on an I2C bus, limited to the read paths. It oversamples SCL and SDA with a fast system clock, recognises Start and Stop conditions, and checks the device select byte against a fixed type code and three strap inputs. A dummy write (select byte with RW=0 followed by two address bytes) loads an internal address counter. The controller then serves reads from a synchronous memory read port and drives the bus open-drain style through an output-enable that pulls SDA low.

Three read forms are supported. A random-address read is a dummy write, a repeated Start and a select byte with RW=1. A current-address read is a select byte with RW=1 on its own. A sequential read continues either form for as long as the master acknowledges. The address counter survives between transactions and wraps to zero past the top of the array.

Top module: `eerd_top`

## Requirements
- R1: While reset is asserted and right after it, `sdaOe` is 0 and `memAddr` is 0.
- R2: The select byte arrives MSB first. Its bits 7..4 must equal 1010, its bits 3..1 must equal `chipSel[2:0]`, and bit 0 is RW (1 = read). On a match the block pulls SDA low (`sdaOe`=1) for the whole high phase of the 9th clock.
- R3: On a select mismatch the block never acknowledges and keeps SDA released for every later clock until the next Start.
- R4: After a select byte with RW=0, the block takes an address high byte and then a low byte and acknowledges each. The counter is loaded with the low `ADDR_W` bits of {high, low}, so high-byte bits above the array size have no effect.
- R5: A repeated Start after the address bytes, followed by a read select, returns the byte at the loaded address. A loaded address also survives a Stop.
- R6: A current-address read returns the byte at the present counter value.
- R7: The counter advances by exactly one after every byte output, whether the master acknowledges or not, and keeps its value across Stop and Start.
- R8: When the master pulls SDA low on the 9th clock after a data byte, the byte at the next address follows on the next eight clocks.
- R9: Past address 2^ADDR_W-1 the counter wraps to 0.
- R10: If SDA is high on the 9th clock after a data byte, the block releases SDA and ignores further clocks until a Start or Stop.
- R11: The level of `wpIn` has no effect on any read, address load or acknowledge.
- R12: `sdaOe` changes only while SCL is low. Data is sent MSB first, and a data bit of 1 is sent by releasing SDA.
- R13: A Start or Stop in the middle of a byte abandons that byte and restarts bit counting; the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock as seen on the pin |
| sdaIn | input | 1 | Bus data as seen on the pin (wired-AND of all drivers) |
| wpIn | input | 1 | Write-control pin; no effect on reads |
| chipSel | input | 3 | Strap levels compared with select bits 3..1 |
| memRdData | input | 8 | Array data, valid one clock after `memAddr` |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| memAddr | output | ADDR_W | Address counter, driven to the array read port |

## Verification
The bench builds the block with `ADDR_W` = 9, a 512-byte array. With this size a sequential read starting at 0x1FE crosses the wrap to 0 within four bytes. It also leaves seven high-byte address bits unused, so an address byte of 0xFF shows that those bits are ignored. The behavioural master compares `sdaOe` with its expected bus level on every clock of each SCL high phase, covering acknowledge slots, data bits and released periods after a mismatch, a NACK or an aborted byte.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEVACK, ST_HI, ST_HIACK, ST_LO, ST_LOACK,
    ST_HOLD, ST_TX, ST_TXACK, ST_TXNEXT
  } ctlState_e;

  // Strobes and drive levels from control to datapath
  typedef struct packed {
    logic bitClr;
    logic hiLoad;
    logic addrLoad;
    logic addrInc;
    logic txLoad;
    logic txShift;
    logic ackOn;
    logic dataOn;
  } ctlStb_t;

  // Bus events and receive state from datapath to control
  typedef struct packed {
    logic       busStart;
    logic       busStop;
    logic       sclRise;
    logic       sclFall;
    logic       sdaBit;
    logic [3:0] bitCnt;
    logic [7:0] rxByte;
  } busStat_t;

endpackage

// File: rtl/eerd_datapath.sv
module eerd_datapath
  import eerd_pkg::*;
#(
  parameter int ADDR_W = 14   // 9..16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [7:0]        memRdData,
  input  ctlStb_t           stb,
  output busStat_t          stat,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memAddr
);
  localparam int HI_W = ADDR_W - 8;

  logic [1:0]        sclSync, sdaSync;
  logic              sclLast, sdaLast;
  logic              sclNow, sdaNow;
  logic [3:0]        bitCnt;
  logic [7:0]        rxReg, rxFull, txReg;
  logic [HI_W-1:0]   hiReg;
  logic [ADDR_W-1:0] addrCnt;

  assign sclNow = sclSync[1];
  assign sdaNow = sdaSync[1];
  assign rxFull = {rxReg[6:0], sdaNow};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclLast <= 1'b1;
      sdaLast <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclLast <= sclNow;
      sdaLast <= sdaNow;
    end
  end

  always_comb begin
    stat.sclRise  = sclNow & ~sclLast;
    stat.sclFall  = ~sclNow & sclLast;
    stat.busStart = sclNow & sclLast & sdaLast & ~sdaNow;
    stat.busStop  = sclNow & sclLast & ~sdaLast & sdaNow;
    stat.sdaBit   = sdaNow;
    stat.bitCnt   = bitCnt;
    stat.rxByte   = rxFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxReg   <= '0;
      txReg   <= '1;
      hiReg   <= '0;
      addrCnt <= '0;
    end else begin
      if (stat.busStart || stat.busStop || stb.bitClr) bitCnt <= '0;
      else if (stat.sclRise)                           bitCnt <= bitCnt + 4'd1;

      if (stat.sclRise) rxReg <= rxFull;

      if (stb.txLoad)       txReg <= memRdData;
      else if (stb.txShift) txReg <= {txReg[6:0], 1'b1};

      if (stb.hiLoad) hiReg <= rxFull[HI_W-1:0];

      if (stb.addrLoad)     addrCnt <= {hiReg, rxFull};
      else if (stb.addrInc) addrCnt <= addrCnt + {{(ADDR_W-1){1'b0}}, 1'b1};
    end
  end

  assign sdaOe   = stb.ackOn | (stb.dataOn & ~txReg[7]);
  assign memAddr = addrCnt;

endmodule

// File: rtl/eerd_control.sv
module eerd_control
  import eerd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] chipSel,
  input  busStat_t   stat,
  output ctlStb_t    stb
);
  ctlState_e state, stateNx;
  logic ackQ, ackNx, dataQ, dataNx, readQ, readNx;
  logic selMatch, byteIn;

  assign selMatch = (stat.rxByte[7:4] == DEV_TYPE) && (stat.rxByte[3:1] == chipSel);
  assign byteIn   = stat.sclRise && (stat.bitCnt == 4'd7);

  always_comb begin
    stateNx = state;
    ackNx   = ackQ;
    dataNx  = dataQ;
    readNx  = readQ;
    stb     = '0;
    if (stat.busStart || stat.busStop) begin
      stateNx    = stat.busStart ? ST_DEV : ST_IDLE;
      stb.bitClr = 1'b1;
      ackNx      = 1'b0;
      dataNx     = 1'b0;
    end else begin
      unique case (state)
        ST_DEV:
          if (byteIn) begin
            stateNx = selMatch ? ST_DEVACK : ST_IDLE;
            readNx  = stat.rxByte[0];
          end
        ST_DEVACK, ST_HIACK, ST_LOACK:
          if (stat.sclFall) begin
            if (!ackQ) ackNx = 1'b1;
            else begin
              ackNx      = 1'b0;
              stb.bitClr = 1'b1;
              if (state == ST_HIACK)      stateNx = ST_LO;
              else if (state == ST_LOACK) stateNx = ST_HOLD;
              else if (readQ) begin
                stateNx    = ST_TX;
                stb.txLoad = 1'b1;
                dataNx     = 1'b1;
              end else stateNx = ST_HI;
            end
          end
        ST_HI:
          if (byteIn) begin
            stb.hiLoad = 1'b1;
            stateNx    = ST_HIACK;
          end
        ST_LO:
          if (byteIn) begin
            stb.addrLoad = 1'b1;
            stateNx      = ST_LOACK;
          end
        ST_TX:
          if (stat.sclFall) begin
            if (stat.bitCnt == 4'd8) begin
              dataNx      = 1'b0;
              stb.addrInc = 1'b1;
              stateNx     = ST_TXACK;
            end else if (stat.bitCnt != 4'd0) stb.txShift = 1'b1;
          end
        ST_TXACK:
          if (stat.sclRise) stateNx = stat.sdaBit ? ST_IDLE : ST_TXNEXT;
        ST_TXNEXT:
          if (stat.sclFall) begin
            stb.txLoad = 1'b1;
            stb.bitClr = 1'b1;
            dataNx     = 1'b1;
            stateNx    = ST_TX;
          end
        default: ;
      endcase
    end
    stb.ackOn  = ackQ;
    stb.dataOn = dataQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ackQ  <= 1'b0;
      dataQ <= 1'b0;
      readQ <= 1'b0;
    end else begin
      state <= stateNx;
      ackQ  <= ackNx;
      dataQ <= dataNx;
      readQ <= readNx;
    end
  end

endmodule

// File: rtl/eerd_top.sv
module eerd_top
  import eerd_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              wpIn,
  input  logic [2:0]        chipSel,
  input  logic [7:0]        memRdData,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memAddr
);
  ctlStb_t  ctlStb;
  busStat_t busStat;
  logic     wpUnused;

  // Reads behave the same at either write-control level
  assign wpUnused = wpIn;

  eerd_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .chipSel (chipSel),
    .stat    (busStat),
    .stb     (ctlStb)
  );

  eerd_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .memRdData (memRdData),
    .stb       (ctlStb),
    .stat      (busStat),
    .sdaOe     (sdaOe),
    .memAddr   (memAddr)
  );

endmodule

// File: rtl/eerd_checker.sv
module eerd_checker
  import eerd_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic [ADDR_W-1:0] memAddr,
  input ctlStb_t           stb,
  input busStat_t          stat
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn); // R12

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.ackOn && stb.dataOn)); // R12

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stat.busStart |=> !sdaOe); // R13

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stat.busStop |=> !sdaOe); // R10

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(memAddr) |-> ($past(stb.addrLoad) || memAddr == $past(memAddr) + ONE)); // R7

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.addrLoad && !stb.addrInc) |=> $stable(memAddr)); // R13

endmodule

bind eerd_top eerd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sclIn   (sclIn),
  .sdaOe   (sdaOe),
  .memAddr (memAddr),
  .stb     (ctlStb),
  .stat    (busStat)
);

// File: tb/sim_eerd_top.sv
`timescale 1ns/1ps
module sim_eerd_top;
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;
  localparam int H     = 8;   // SCL half period in clocks

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sclIn = 1'b1;
  logic          mSda = 1'b1;
  logic          wpIn = 1'b0;
  logic [2:0]    chipSel = 3'b101;
  logic [7:0]    memRdData;
  logic          sdaOe;
  logic [AW-1:0] memAddr;
  wire           sdaIn = mSda & ~sdaOe;

  logic [7:0] mem [0:DEPTH-1];
  int checks = 0, errors = 0, modelAddr = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) memRdData <= mem[memAddr];

  eerd_top #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .wpIn(wpIn),
    .chipSel(chipSel), .memRdData(memRdData), .sdaOe(sdaOe), .memAddr(memAddr)
  );

  task automatic chkBit(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s sdaOe got %b exp %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chkAddr(input string tag);
    checks++;
    if (int'(memAddr) != modelAddr) begin
      errors++;
      $display("FAIL %s memAddr got %0h exp %0h", tag, memAddr, modelAddr);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic highPhase(input logic exp, input string tag);
    for (int i = 0; i < H; i++) begin
      @(negedge clk);
      chkBit(sdaOe, exp, tag);
    end
  endtask

  // One SCL bit: master level during the bit, expected sdaOe while SCL high
  task automatic slot(input logic drive, input logic exp, input string tag);
    @(negedge clk); sclIn = 1'b0;
    waitClk(2); mSda = drive;
    waitClk(H - 2); sclIn = 1'b1;
    highPhase(exp, tag);
  endtask

  task automatic startCond(input string tag);
    @(negedge clk); sclIn = 1'b0;
    waitClk(H); mSda = 1'b1;
    waitClk(H); sclIn = 1'b1;
    highPhase(1'b0, tag);
    mSda = 1'b0;
    highPhase(1'b0, tag);
  endtask

  task automatic stopCond(input string tag);
    @(negedge clk); sclIn = 1'b0;
    waitClk(H); mSda = 1'b0;
    waitClk(H); sclIn = 1'b1;
    highPhase(1'b0, tag);
    mSda = 1'b1;
    highPhase(1'b0, tag);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string tag);
    for (int i = 7; i >= 0; i--) slot(b[i], 1'b0, tag);
    slot(1'b1, expAck, tag);
  endtask

  task automatic readByte(input logic masterAck, input string tag);
    logic [7:0] d;
    d = mem[modelAddr];
    for (int i = 7; i >= 0; i--) slot(1'b1, ~d[i], tag);
    modelAddr = (modelAddr + 1) % DEPTH;
    slot(~masterAck, 1'b0, tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    waitClk(5);
    chkBit(sdaOe, 1'b0, "R1 reset oe");
    chkAddr("R1 reset addr");
    rstN = 1'b1;
    waitClk(4);
    chkBit(sdaOe, 1'b0, "R1 after reset oe");
    chkAddr("R1 after reset addr");

    // R6 current-address read at 0, NACK, then R10 standby clocks
    startCond("R6 start");
    sendByte(8'b1010_101_1, 1'b1, "R2 read select ack");
    readByte(1'b0, "R6 current read");
    for (int i = 0; i < 9; i++) slot(1'b1, 1'b0, "R10 standby after nack");
    stopCond("R10 stop");
    chkAddr("R7 increment after byte");

    // R4 R5 random read with unused high bits set; R11 wp high
    wpIn = 1'b1;
    startCond("R4 start");
    sendByte(8'b1010_101_0, 1'b1, "R4 write select ack");
    sendByte(8'hFF, 1'b1, "R4 high byte ack");
    sendByte(8'h20, 1'b1, "R4 low byte ack");
    modelAddr = 'h120;
    startCond("R5 repeated start");
    sendByte(8'b1010_101_1, 1'b1, "R5 read select ack");
    readByte(1'b0, "R5 random read R11");
    stopCond("R5 stop");
    chkAddr("R4 loaded address plus one");

    // R8 R9 sequential read across the top of the array
    startCond("R8 start");
    sendByte(8'b1010_101_0, 1'b1, "R8 write select");
    sendByte(8'h01, 1'b1, "R8 high byte");
    wpIn = 1'b0;
    sendByte(8'hFE, 1'b1, "R8 low byte R11");
    modelAddr = 'h1FE;
    startCond("R8 repeated start");
    sendByte(8'b1010_101_1, 1'b1, "R8 read select");
    readByte(1'b1, "R8 seq byte 1FE");
    readByte(1'b1, "R9 seq byte 1FF");
    wpIn = 1'b1;
    readByte(1'b1, "R9 wrapped byte 000");
    readByte(1'b0, "R9 seq byte 001");
    stopCond("R8 stop");
    chkAddr("R9 address after wrap");

    // R7 counter survives Stop: current-address read continues
    startCond("R7 start");
    sendByte(8'b1010_101_1, 1'b1, "R7 read select");
    readByte(1'b1, "R7 continued read");
    readByte(1'b0, "R7 continued read 2");
    stopCond("R7 stop");
    chkAddr("R7 address persists");

    // R3 mismatched straps and type
    startCond("R3 start");
    sendByte(8'b1010_011_1, 1'b0, "R3 strap mismatch no ack");
    sendByte(8'h00, 1'b0, "R3 released after mismatch");
    startCond("R3 start 2");
    sendByte(8'b1011_101_1, 1'b0, "R3 type mismatch no ack");
    sendByte(8'hA5, 1'b0, "R3 released after type mismatch");
    stopCond("R3 stop");
    chkAddr("R3 address untouched");

    // R13 Start in mid byte
    startCond("R13 start");
    sendByte(8'b1010_101_0, 1'b1, "R13 write select");
    slot(1'b1, 1'b0, "R13 partial bit");
    slot(1'b0, 1'b0, "R13 partial bit");
    slot(1'b1, 1'b0, "R13 partial bit");
    startCond("R13 abort start");
    sendByte(8'b1010_101_1, 1'b1, "R13 select after abort");
    readByte(1'b0, "R13 read after abort");
    stopCond("R13 stop");
    chkAddr("R13 address kept after start abort");

    // R13 Stop in mid low byte
    startCond("R13 start b");
    sendByte(8'b1010_101_0, 1'b1, "R13 write select b");
    sendByte(8'h00, 1'b1, "R13 high byte b");
    for (int i = 0; i < 4; i++) slot(1'b0, 1'b0, "R13 partial low byte");
    stopCond("R13 abort stop");
    chkAddr("R13 address kept after stop abort");

    // R5 loaded address survives a Stop
    startCond("R5 start b");
    sendByte(8'b1010_101_0, 1'b1, "R5 write select b");
    sendByte(8'h00, 1'b1, "R5 high byte b");
    sendByte(8'h40, 1'b1, "R5 low byte b");
    stopCond("R5 stop after load");
    modelAddr = 'h40;
    chkAddr("R5 loaded address");
    startCond("R5 start c");
    sendByte(8'b1010_101_1, 1'b1, "R5 read select c");
    readByte(1'b0, "R5 read loaded address");
    stopCond("R5 stop c");
    chkAddr("R7 final address");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule